// File: doc/BRIEF.md
# UART Receive Buffer with Status

This block holds the bytes a UART receiver has finished deserialising until host software reads them. Each byte arrives as a one-cycle `rx_valid` strobe with `rx_data`. In queued mode it goes into a circular FIFO that holds `DEPTH` bytes, 16 by default. In direct mode it overwrites a single holding register. A line break is signalled on `rx_break`. The deserialiser reports parity and framing faults alongside a byte.

A small host register port gives access to five words at addresses 0 to 4:
- address 0: the control word
- address 1: the fill status
- address 2: the data port
- address 3: the data-ready flag
- address 4: the error-status word, which clears when read

Two registered event pulses, `rx_event` and `err_event`, feed an interrupt controller. The block also pulses `tx_fifo_flush` so that a separate transmit queue can be emptied from the same control word.

Flush requests in the control word are handled by a two-state machine:
- ST_IDLE goes to ST_FLUSH on a control write that sets either reset bit.
- ST_FLUSH empties the receive FIFO and/or pulses the transmit flush, clears the request bits, and returns to ST_IDLE. If a new request is written during that cycle, it stays in ST_FLUSH instead.

Top module: `uart_rx_buffer`

## Requirements
- R1: After reset, the control word, the status word, the ready flag and the error-status word all read 0, and `rx_event`, `err_event` and `tx_fifo_flush` are low.
- R2: In queued mode (control bit 0 = 1), each read of address 2 returns one stored byte and removes it. Bytes come out in arrival order.
- R3: The status word at address 1 carries the fill count in bits 7:0. When the FIFO is full it reads 0x100: bit 8 is set and the count field is 0.
- R4: Ready (address 3, bit 0) sets when a byte is accepted. It stays set while bytes remain and clears when a read empties the FIFO.
- R5: A data read from an empty FIFO in queued mode returns 0, and `err_event` is high in the cycle after the read.
- R6: A byte arriving at a full FIFO is dropped, leaving the contents unchanged. `err_event` pulses and error-status bit 0 (overrun) is set.
- R7: In direct mode (control bit 0 = 0), each byte overwrites the holding register and sets ready. A data read returns the latest byte and clears ready.
- R8: A break stores a zero byte, in the same way as a received byte, and sets error-status bit 3.
- R9: Error-status bit 1 records a parity fault and bit 2 a framing fault; both are qualified by `rx_valid`. A read of address 4 returns the word and clears it to 0.
- R10: Writing control bit 1 empties the receive FIFO and clears ready. Writing control bit 2 drives `tx_fifo_flush` high for one cycle. Both bits read back as 0 once the flush is done, and bit 0 keeps its written value.
- R11: `rx_event` is high in the cycle after each accepted byte.
- R12: The order of bytes is preserved when the read and write positions wrap past the last entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | A received byte is on rx_data this cycle |
| rx_data | input | DATA_W | Received byte |
| rx_break | input | 1 | Break detected on the line |
| rx_parity_err | input | 1 | Parity fault for the byte on rx_data |
| rx_frame_err | input | 1 | Framing fault for the byte on rx_data |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe; read side effects take place at the clock edge |
| host_addr | input | 3 | Register address: 0 control, 1 status, 2 data, 3 ready, 4 error status |
| host_wdata | input | 3 | Control write data |
| host_rdata | output | 32 | Read data, combinational from the addressed register |
| rx_event | output | 1 | Pulse after an accepted byte |
| err_event | output | 1 | Pulse after a dropped byte or an empty read |
| tx_fifo_flush | output | 1 | One-cycle request to empty the transmit queue |

## Verification
The hardest case to reach is the full FIFO. The drop path, the 0x100 status encoding and the overrun bit are only visible after exactly `DEPTH` unread bytes have been queued. The stimulus therefore enables queued mode, sends `DEPTH` bytes through the scoreboard driver, checks the status word, and then sends one more byte. It then drains the whole FIFO and checks that the extra byte never appears before the empty-read error. Wrap-around is reached by running further fill-and-drain rounds after that drain.

// File: rtl/uart_rxb_pkg.sv
package uart_rxb_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_FLUSH = 1'b1
    } flush_state_e;

    localparam logic [2:0] ADR_CTRL  = 3'd0;
    localparam logic [2:0] ADR_STAT  = 3'd1;
    localparam logic [2:0] ADR_DATA  = 3'd2;
    localparam logic [2:0] ADR_READY = 3'd3;
    localparam logic [2:0] ADR_ERR   = 3'd4;

    localparam int CTL_EN  = 0;
    localparam int CTL_RXR = 1;
    localparam int CTL_TXR = 2;

    localparam int ERR_OVR = 0;
    localparam int ERR_PAR = 1;
    localparam int ERR_FRM = 2;
    localparam int ERR_BRK = 3;
    localparam int ERR_W   = 4;
endpackage

// File: rtl/uart_rxb_fifo.sv
module uart_rxb_fifo #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [CW-1:0]     count,
    output logic              full,
    output logic              empty
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
    assign head  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push && !full && !clear) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push && !full)  wr_ptr <= bump(wr_ptr);
            if (pop && !empty)  rd_ptr <= bump(rd_ptr);
            case ({push && !full, pop && !empty})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R3
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> empty); // R10
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop && !clear) |=> full); // R6
endmodule

// File: rtl/uart_rxb_ctrl.sv
module uart_rxb_ctrl
    import uart_rxb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_ctrl,
    input  logic [2:0] wdata,
    output logic       fifo_en,
    output logic [2:0] ctrl_word,
    output logic       rx_clear,
    output logic       tx_flush
);
    flush_state_e state_q, state_d;
    logic         pend_rx, pend_tx;
    logic         req;

    assign req = wr_ctrl && (wdata[CTL_RXR] || wdata[CTL_TXR]);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = req ? ST_FLUSH : ST_IDLE;
            ST_FLUSH: state_d = req ? ST_FLUSH : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fifo_en <= 1'b0;
            pend_rx <= 1'b0;
            pend_tx <= 1'b0;
        end else if (wr_ctrl) begin
            fifo_en <= wdata[CTL_EN];
            pend_rx <= wdata[CTL_RXR];
            pend_tx <= wdata[CTL_TXR];
        end else if (state_q == ST_FLUSH) begin
            pend_rx <= 1'b0;
            pend_tx <= 1'b0;
        end
    end

    always_comb begin
        rx_clear  = 1'b0;
        tx_flush  = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_FLUSH: begin
                rx_clear = pend_rx;
                tx_flush = pend_tx;
            end
            default:  ;
        endcase
        ctrl_word = {pend_tx, pend_rx, fifo_en};
    end

    AST_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLUSH && !wr_ctrl) |=> (!pend_rx && !pend_tx && state_q == ST_IDLE)); // R10
    AST_TXF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_flush && !wr_ctrl) |=> !tx_flush); // R10
endmodule

// File: rtl/uart_rxb_errst.sv
module uart_rxb_errst
    import uart_rxb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ERR_W-1:0]  set,
    input  logic              rd_clr,
    output logic [ERR_W-1:0]  value
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      value <= '0;
        else if (rd_clr) value <= set;
        else             value <= value | set;
    end

    AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && set == '0) |=> (value == '0)); // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_clr && value[ERR_BRK]) |=> value[ERR_BRK]); // R8
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
    import uart_rxb_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_break,
    input  logic              rx_parity_err,
    input  logic              rx_frame_err,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [2:0]        host_addr,
    input  logic [2:0]        host_wdata,
    output logic [31:0]       host_rdata,
    output logic              rx_event,
    output logic              err_event,
    output logic              tx_fifo_flush
);
    localparam int CW = $clog2(DEPTH + 1);

    logic              fifo_en, fifo_clear;
    logic [2:0]        ctrl_word;
    logic [DATA_W-1:0] head, hold, in_byte;
    logic [CW-1:0]     count;
    logic              full, empty;
    logic              accept_in, fifo_push, direct_wr, drop;
    logic              rd_data, pop, empty_rd, ready;
    logic [ERR_W-1:0]  err_set, err_val;

    assign accept_in = rx_valid || rx_break;
    assign in_byte   = rx_break ? '0 : rx_data;
    assign fifo_push = accept_in && fifo_en && !full && !fifo_clear;
    assign direct_wr = accept_in && !fifo_en;
    assign drop      = accept_in && fifo_en && full && !fifo_clear;
    assign rd_data   = host_rd && host_addr == ADR_DATA;
    assign pop       = rd_data && fifo_en && !empty && !fifo_clear;
    assign empty_rd  = rd_data && fifo_en && empty;

    uart_rxb_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl   (host_wr && host_addr == ADR_CTRL),
        .wdata     (host_wdata),
        .fifo_en   (fifo_en),
        .ctrl_word (ctrl_word),
        .rx_clear  (fifo_clear),
        .tx_flush  (tx_fifo_flush)
    );

    uart_rxb_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (fifo_clear),
        .push      (fifo_push),
        .push_data (in_byte),
        .pop       (pop),
        .head      (head),
        .count     (count),
        .full      (full),
        .empty     (empty)
    );

    always_comb begin
        err_set          = '0;
        err_set[ERR_OVR] = drop;
        err_set[ERR_PAR] = rx_valid && rx_parity_err;
        err_set[ERR_FRM] = rx_valid && rx_frame_err;
        err_set[ERR_BRK] = rx_break;
    end

    uart_rxb_errst u_err (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (err_set),
        .rd_clr (host_rd && host_addr == ADR_ERR),
        .value  (err_val)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold      <= '0;
            ready     <= 1'b0;
            rx_event  <= 1'b0;
            err_event <= 1'b0;
        end else begin
            if (direct_wr) hold <= in_byte;
            if (fifo_clear)                      ready <= 1'b0;
            else if (fifo_push || direct_wr)     ready <= 1'b1;
            else if (pop && count == CW'(1))     ready <= 1'b0;
            else if (rd_data && !fifo_en)        ready <= 1'b0;
            rx_event  <= fifo_push || direct_wr;
            err_event <= drop || empty_rd;
        end
    end

    always_comb begin
        host_rdata = '0;
        case (host_addr)
            ADR_CTRL:  host_rdata = {29'd0, ctrl_word};
            ADR_STAT:  host_rdata = full ? 32'h100 : {{(32-CW){1'b0}}, count};
            ADR_DATA:  host_rdata = fifo_en ? (empty ? '0 : {{(32-DATA_W){1'b0}}, head})
                                            : {{(32-DATA_W){1'b0}}, hold};
            ADR_READY: host_rdata = {31'd0, ready};
            ADR_ERR:   host_rdata = {{(32-ERR_W){1'b0}}, err_val};
            default:   host_rdata = '0;
        endcase
    end

    AST_EMPTY_READ_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        empty_rd |=> err_event); // R5
    AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> (err_event && err_val[ERR_OVR])); // R6
    AST_READY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && count == CW'(1) && !fifo_push) |=> !ready); // R4
    AST_RX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |=> (rx_event && ready)); // R11
endmodule

// File: tb/sim_uart_rx_buffer.sv
module sim_uart_rx_buffer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0, rx_break = 1'b0, rx_parity_err = 1'b0, rx_frame_err = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [2:0]  host_addr = '0, host_wdata = '0;
    logic [31:0] host_rdata;
    logic        rx_event, err_event, tx_fifo_flush;

    int total = 0, bad = 0;
    bit done = 0;
    logic [7:0] exp_q [$];
    logic last_rx, last_err;
    logic [31:0] rv;

    always #2 clk = ~clk;

    uart_rx_buffer u0 (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(logic [2:0] a, logic [2:0] d);
        @(negedge clk); host_wr = 1; host_addr = a; host_wdata = d;
        @(negedge clk); host_wr = 0;
    endtask

    task automatic reg_read(logic [2:0] a, output logic [31:0] d);
        @(negedge clk); host_rd = 1; host_addr = a;
        #1 d = host_rdata;
        @(negedge clk); host_rd = 0; last_err = err_event;
    endtask

    // driver: pushes the expected item when the byte should be queued
    task automatic send(logic [7:0] b, bit brk, bit par, bit frm, bit expect_store);
        @(negedge clk); rx_valid = !brk; rx_break = brk; rx_data = b;
        rx_parity_err = par; rx_frame_err = frm;
        @(negedge clk); rx_valid = 0; rx_break = 0; rx_parity_err = 0; rx_frame_err = 0;
        last_rx = rx_event; last_err = err_event;
        if (expect_store) exp_q.push_back(brk ? 8'h00 : b);
    endtask

    // monitor side: pops the next expected item and compares
    task automatic pop_check(string req);
        logic [7:0] e;
        e = exp_q.pop_front();
        reg_read(3'd2, rv);
        chk(req, rv, {24'd0, e});
    endtask

    initial begin
        #400000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset values
        chk("R1 events", {29'd0, rx_event, err_event, tx_fifo_flush}, 0);
        reg_read(3'd0, rv); chk("R1 ctrl", rv, 0);
        reg_read(3'd1, rv); chk("R1 status", rv, 0);
        reg_read(3'd3, rv); chk("R1 ready", rv, 0);
        reg_read(3'd4, rv); chk("R1 errst", rv, 0);

        // R7 direct mode
        send(8'h41, 0, 0, 0, 0);
        chk("R11 rx_event direct", {31'd0, last_rx}, 1);
        reg_read(3'd3, rv); chk("R7 ready set", rv, 1);
        send(8'h42, 0, 0, 0, 0);
        reg_read(3'd2, rv); chk("R7 latest byte", rv, 32'h42);
        reg_read(3'd3, rv); chk("R7 ready cleared", rv, 0);

        // R2/R3/R4 queued mode
        reg_write(3'd0, 3'b001);
        for (int i = 0; i < 5; i++) send(8'h10 + 8'(i), 0, 0, 0, 1);
        chk("R11 rx_event queued", {31'd0, last_rx}, 1);
        reg_read(3'd1, rv); chk("R3 count 5", rv, 5);
        reg_read(3'd3, rv); chk("R4 ready set", rv, 1);
        for (int i = 0; i < 4; i++) pop_check("R2 order");
        reg_read(3'd3, rv); chk("R4 ready stays", rv, 1);
        pop_check("R2 last");
        reg_read(3'd3, rv); chk("R4 ready clears", rv, 0);

        // R5 empty read
        reg_read(3'd2, rv);
        chk("R5 empty data", rv, 0);
        chk("R5 err_event", {31'd0, last_err}, 1);

        // R3/R6 full and drop
        for (int i = 0; i < 16; i++) send(8'h80 + 8'(i), 0, 0, 0, 1);
        reg_read(3'd1, rv); chk("R3 full status", rv, 32'h100);
        send(8'hEE, 0, 0, 0, 0);
        chk("R6 err_event", {31'd0, last_err}, 1);
        chk("R6 no rx_event", {31'd0, last_rx}, 0);
        reg_read(3'd4, rv); chk("R6 overrun bit", rv, 1);
        reg_read(3'd4, rv); chk("R9 clear on read", rv, 0);
        for (int i = 0; i < 16; i++) pop_check("R6 contents kept");
        reg_read(3'd1, rv); chk("R6 dropped byte absent", rv, 0);

        // R12 wrap
        for (int r = 0; r < 3; r++) begin
            for (int i = 0; i < 11; i++) send(8'(r * 16 + i + 3), 0, 0, 0, 1);
            for (int i = 0; i < 11; i++) pop_check("R12 wrap order");
        end

        // R8 break, R9 parity/frame
        send(8'h5A, 1, 0, 0, 1);
        pop_check("R8 zero byte");
        reg_read(3'd4, rv); chk("R8 break bit", rv, 32'h8);
        send(8'h33, 0, 1, 1, 1);
        reg_read(3'd4, rv); chk("R9 parity+frame", rv, 32'h6);
        pop_check("R9 byte kept");

        // R10 flush
        for (int i = 0; i < 3; i++) send(8'hC0 + 8'(i), 0, 0, 0, 1);
        reg_write(3'd0, 3'b111);
        chk("R10 tx flush pulse", {31'd0, tx_fifo_flush}, 1);
        exp_q.delete();
        reg_read(3'd0, rv); chk("R10 self clear", rv, 1);
        reg_read(3'd1, rv); chk("R10 fifo emptied", rv, 0);
        reg_read(3'd3, rv); chk("R10 ready cleared", rv, 0);
        chk("R10 tx flush ended", {31'd0, tx_fifo_flush}, 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule